// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the target side of a three-wire serial link into a 16-entry, 8-bit register file. An access window is open only while both enable inputs are high. Inside a window, the host first sends a 4-bit operation code and then a 4-bit starting register index, and after that it moves whole bytes in or out. Every field travels least-significant bit first. After each whole byte the register index steps forward by one, and it wraps from the last entry back to the first.

The serial pins are asynchronous to the block clock. They pass through a synchronizer, and the serial clock's rising edges are found in the block clock domain, so the block clock must run several times faster than the serial clock. Writes leave on a one-cycle write strobe with index and byte. Reads fetch the byte through a plain index/data read port. The bidirectional pad is split into a data-in pin, a data-out pin and an output enable. A write byte cut short when the window closes is dropped and reported on an abort pulse. A one-cycle clear pulse tells the register file to zero its volatile flag bits each time the window closes.

The write port is a strobe with no ready. A serial host cannot be stalled, so the register file must accept a write in any cycle. The same reasoning applies to the read port: `rd_data` must be valid in the cycle after `rd_addr` changes.

Top module: `tws_regport`

## Requirements
- R1: An access window exists only while `ce_a` and `ce_b` are both high. With either one low, serial clock edges cause no write strobe, no abort and no output enable.
- R2: The first four bits after the window opens form an operation code, least-significant bit first. The value 4'h3 selects write and 4'hC selects read.
- R3: Any other operation code makes the block ignore every later bit of that window. No write strobe is issued and `sdo_oe` stays low.
- R4: The four bits after the operation code give the starting register index, least-significant bit first.
- R5: In write mode, `sdi` is taken on each serial clock rise. After the eighth bit of a byte, one `wr_valid` pulse carries the current index and the byte. The first bit taken is bit 0.
- R6: After every complete byte, in either mode, the index increments by one and wraps from 4'hF to 4'h0.
- R7: In read mode, `sdo_oe` is high throughout the data phase. Bit i of the byte at the current index is driven on `sdo` from the (i+1)-th serial clock rise of that byte until the next rise. The byte is fetched after the index nibble and again after each byte boundary.
- R8: If the window closes while a write byte is partly received, that byte is discarded and `wr_abort` pulses for one cycle. Bytes finished earlier stay written. A closing that is sampled in the same cycle as the final bit's rise also counts as incomplete.
- R9: Each closing of the window produces exactly one single-cycle `ce_clr` pulse. The pulse asks the register file to clear its update-seen flag, its test bit and its reset bit.
- R10: `sdo_oe` drops no later than the cycle in which the synchronized enable is seen low, and `sdo` is 0 whenever `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a | input | 1 | First enable input |
| ce_b | input | 1 | Second enable input |
| sclk | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data from the pad |
| sdo | output | 1 | Serial data to the pad |
| sdo_oe | output | 1 | Pad output enable |
| rd_addr | output | 4 | Register file read index |
| rd_data | input | 8 | Register file read data |
| wr_valid | output | 1 | Single-cycle write strobe |
| wr_addr | output | 4 | Write index |
| wr_data | output | 8 | Write byte |
| wr_abort | output | 1 | Pulse: partial write byte discarded |
| ce_clr | output | 1 | Pulse: window closed, clear volatile flags |

## Verification
The two functions that can fall in the same cycle are completing a write byte and closing the window. The bench raises the serial clock for the eighth bit and drops the enable inputs in the same block-clock cycle. The behavioural model expects the closing to take priority: the register file entry must keep its old value, and an abort and a clear pulse appear together with no write strobe. Every output is compared with the model on every clock, so a strobe leaking through in that cycle is seen at once.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int MW = 4;
  localparam logic [MW-1:0] OP_WRITE = 4'h3;
  localparam logic [MW-1:0] OP_READ  = 4'hC;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_IDX,
    ST_WBYTE,
    ST_RBYTE,
    ST_SKIP
  } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_shift.sv
module tws_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sdi_s,
  input  logic          in_en,
  input  logic          load_en,
  input  logic [DW-1:0] load_word,
  input  logic          out_en,
  input  logic          out_clr,
  output logic [DW-1:0] in_next,
  output logic          out_bit
);
  logic [DW-1:0] in_sh;
  logic [DW-1:0] out_sh;

  assign in_next = {sdi_s, in_sh[DW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_sh   <= '0;
      out_sh  <= '0;
      out_bit <= 1'b0;
    end else begin
      if (in_en) in_sh <= in_next;
      if (out_clr) begin
        out_bit <= 1'b0;
      end else if (out_en) begin
        out_bit <= out_sh[0];
        out_sh  <= out_sh >> 1;
      end
      if (load_en) out_sh <= load_word;
    end
  end

  // a bit is never taken in and driven out by the same rise (R7)
  assert_dir_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !in_en);
endmodule

// File: rtl/tws_seq.sv
module tws_seq
  import tws_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          sclk_s,
  input  logic [DW-1:0] in_next,
  output logic          in_en,
  output logic          out_en,
  output logic          out_clr,
  output logic          load_en,
  output logic [AW-1:0] idx,
  output logic          oe,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_abort,
  output logic          ce_clr
);
  localparam int LIM = (DW > MW) ? DW : MW;
  localparam int CW  = (LIM > 1) ? $clog2(LIM) : 1;

  tws_state_e    state;
  logic [CW-1:0] cnt;
  logic          is_wr;
  logic          sclk_d, ce_d;
  logic          rise, ce_up, ce_dn, step;
  logic [MW-1:0] op_code;

  assign rise    = sclk_s & ~sclk_d;
  assign ce_up   = ce_s & ~ce_d;
  assign ce_dn   = ~ce_s & ce_d;
  assign step    = rise & ce_s & ~ce_up;
  assign op_code = in_next[DW-1 -: MW];

  assign in_en   = step && (state == ST_OP || state == ST_IDX || state == ST_WBYTE);
  assign out_en  = step && (state == ST_RBYTE);
  assign out_clr = ce_up;
  assign oe      = ce_s && (state == ST_RBYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      ce_d   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      ce_d   <= ce_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      idx      <= '0;
      load_en  <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      wr_abort <= 1'b0;
      ce_clr   <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      wr_abort <= 1'b0;
      ce_clr   <= 1'b0;
      load_en  <= 1'b0;
      if (ce_dn) begin
        ce_clr   <= 1'b1;
        wr_abort <= (state == ST_WBYTE) && (cnt != '0);
        state    <= ST_IDLE;
        cnt      <= '0;
      end else if (ce_up) begin
        state <= ST_OP;
        cnt   <= '0;
      end else if (step) begin
        unique case (state)
          ST_OP: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(MW-1)) begin
              cnt <= '0;
              if (op_code == OP_WRITE) begin
                state <= ST_IDX;
                is_wr <= 1'b1;
              end else if (op_code == OP_READ) begin
                state <= ST_IDX;
                is_wr <= 1'b0;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_IDX: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(AW-1)) begin
              cnt     <= '0;
              idx     <= in_next[DW-1 -: AW];
              state   <= is_wr ? ST_WBYTE : ST_RBYTE;
              load_en <= ~is_wr;
            end
          end
          ST_WBYTE: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              cnt      <= '0;
              wr_valid <= 1'b1;
              wr_addr  <= idx;
              wr_data  <= in_next;
              idx      <= idx + 1'b1;
            end
          end
          ST_RBYTE: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DW-1)) begin
              cnt     <= '0;
              idx     <= idx + 1'b1;
              load_en <= 1'b1;
            end
          end
          default: cnt <= cnt;
        endcase
      end
    end
  end

  // the index has moved one step past the byte just written (R6)
  assert_index_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> idx == AW'(wr_addr + 1'b1));
  // a byte is either committed or dropped, never both (R8)
  assert_abort_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_abort));
  // clear request lasts a single cycle (R9)
  assert_clr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_clr |=> !ce_clr);
  // the pad is released once the closing has been acted on (R10)
  assert_oe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_clr |-> !oe);
  // an unknown code leaves the window silent (R3)
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> !wr_valid && !oe);
endmodule

// File: rtl/tws_regport.sv
module tws_regport #(
  parameter int AW          = 4,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_a,
  input  logic          ce_b,
  input  logic          sclk,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_abort,
  output logic          ce_clr
);
  logic [2:0]    pins_s;
  logic          ce_s, sclk_s, sdi_s;
  logic          in_en, out_en, out_clr, load_en, oe, out_bit;
  logic [DW-1:0] in_next;

  tws_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ce_a & ce_b, sclk, sdi}),
    .q     (pins_s)
  );
  assign {ce_s, sclk_s, sdi_s} = pins_s;

  tws_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_s     (ce_s),
    .sclk_s   (sclk_s),
    .in_next  (in_next),
    .in_en    (in_en),
    .out_en   (out_en),
    .out_clr  (out_clr),
    .load_en  (load_en),
    .idx      (rd_addr),
    .oe       (oe),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_abort (wr_abort),
    .ce_clr   (ce_clr)
  );

  tws_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdi_s     (sdi_s),
    .in_en     (in_en),
    .load_en   (load_en),
    .load_word (rd_data),
    .out_en    (out_en),
    .out_clr   (out_clr),
    .in_next   (in_next),
    .out_bit   (out_bit)
  );

  assign sdo_oe = oe;
  assign sdo    = out_bit & oe;

  // data line is quiet whenever it is not driven (R10)
  assert_sdo_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_oe |-> !sdo);
endmodule

// File: tb/tb_tws_regport.sv
`timescale 1ns/1ps
module tb_tws_regport;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_a = 1'b0, ce_b = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, wr_valid, wr_abort, ce_clr;
  logic [3:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic [7:0] regs [16];
  logic [7:0] mregs [16];

  int checks = 0, errors = 0;
  int wv_cnt = 0, ab_cnt = 0, oe_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tws_regport dut (
    .clk(clk), .rst_n(rst_n), .ce_a(ce_a), .ce_b(ce_b), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_abort(wr_abort), .ce_clr(ce_clr)
  );

  // register file behind the port
  assign rd_data = regs[rd_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'(i * 29 + 7);
    end else begin
      if (wr_valid) regs[wr_addr] <= wr_data;
      if (wr_valid) wv_cnt <= wv_cnt + 1;
      if (wr_abort) ab_cnt <= ab_cnt + 1;
      if (sdo_oe)   oe_cnt <= oe_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: pins seen two clocks late, edges against the sample before
  localparam int P_IDLE = 0, P_OP = 1, P_IDX = 2, P_WR = 3, P_RD = 4, P_SKIP = 5;
  logic [2:0] h1, h2, h3;
  int   m_ph, m_n, m_acc, m_idx;
  bit   m_wr;
  logic e_wv, e_ab, e_clr, e_oe, e_bit;
  logic [3:0] e_wa;
  logic [7:0] e_wd;

  always @(posedge clk) begin
    if (!rst_n) begin
      h1 = '0; h2 = '0; h3 = '0;
      m_ph = P_IDLE; m_n = 0; m_acc = 0; m_idx = 0; m_wr = 1'b0;
      e_wv = 0; e_ab = 0; e_clr = 0; e_oe = 0; e_bit = 0; e_wa = 0; e_wd = 0;
      for (int i = 0; i < 16; i++) mregs[i] = 8'(i * 29 + 7);
    end else begin
      e_wv = 0; e_ab = 0; e_clr = 0;
      if (!h2[2] && h3[2]) begin
        e_clr = 1;
        if (m_ph == P_WR && m_n != 0) e_ab = 1;
        m_ph = P_IDLE;
      end else if (h2[2] && !h3[2]) begin
        m_ph = P_OP; m_n = 0; m_acc = 0; e_bit = 0;
      end else if (h2[2] && h2[1] && !h3[1]) begin
        case (m_ph)
          P_OP: begin
            m_acc |= int'(h2[0]) << m_n; m_n++;
            if (m_n == 4) begin
              if (m_acc == 3)       begin m_ph = P_IDX; m_wr = 1; end
              else if (m_acc == 12) begin m_ph = P_IDX; m_wr = 0; end
              else m_ph = P_SKIP;
              m_n = 0; m_acc = 0;
            end
          end
          P_IDX: begin
            m_acc |= int'(h2[0]) << m_n; m_n++;
            if (m_n == 4) begin
              m_idx = m_acc; m_ph = m_wr ? P_WR : P_RD; m_n = 0; m_acc = 0;
            end
          end
          P_WR: begin
            m_acc |= int'(h2[0]) << m_n; m_n++;
            if (m_n == 8) begin
              e_wv = 1; e_wa = 4'(m_idx); e_wd = 8'(m_acc);
              mregs[m_idx] = 8'(m_acc);
              m_idx = (m_idx + 1) % 16; m_n = 0; m_acc = 0;
            end
          end
          P_RD: begin
            e_bit = mregs[m_idx][m_n]; m_n++;
            if (m_n == 8) begin m_idx = (m_idx + 1) % 16; m_n = 0; end
          end
          default: ;
        endcase
      end
      e_oe = (m_ph == P_RD) && h1[2];
      h3 = h2; h2 = h1; h1 = {ce_a & ce_b, sclk, sdi};
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(wr_valid == e_wv, "R5", "wr_valid", wr_valid, e_wv);
      if (e_wv) begin
        check(wr_addr == e_wa, "R6", "wr_addr", wr_addr, e_wa);
        check(wr_data == e_wd, "R5", "wr_data", wr_data, e_wd);
      end
      check(wr_abort == e_ab, "R8", "wr_abort", wr_abort, e_ab);
      check(ce_clr == e_clr, "R9", "ce_clr", ce_clr, e_clr);
      check(sdo_oe == e_oe, "R7", "sdo_oe", sdo_oe, e_oe);
      check(sdo == (e_oe & e_bit), "R7", "sdo", sdo, e_oe & e_bit);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic sbit(input logic b);
    sdi = b; sclk = 1'b0; tick(4);
    sclk = 1'b1; tick(4);
  endtask
  task automatic snib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) sbit(v[i]);
  endtask
  task automatic sbyte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sbit(v[i]);
  endtask
  task automatic open_win(input logic [3:0] op, input logic [3:0] a);
    ce_a = 1'b1; ce_b = 1'b1; tick(6);
    snib(op); snib(a);
  endtask
  task automatic close_win();
    sclk = 1'b0; tick(4);
    ce_a = 1'b0; ce_b = 1'b0; tick(8);
  endtask

  initial begin
    int w0, a0, o0;
    tick(5); rst_n = 1'b1; tick(3);
    check(!sdo_oe && !wr_valid && !wr_abort && !ce_clr && !sdo, "R1", "reset outputs quiet",
          {sdo_oe, wr_valid, wr_abort, ce_clr, sdo}, 0);

    // R2 R4 R5: write two bytes from index 2
    open_win(4'h3, 4'h2); sbyte(8'hA5); sbyte(8'h3C); close_win();
    check(regs[2] == 8'hA5, "R5", "regs[2]", regs[2], 8'hA5);
    check(regs[3] == 8'h3C, "R6", "regs[3]", regs[3], 8'h3C);

    // R7: read three bytes back from index 2
    open_win(4'hC, 4'h2); sbyte(8'h00); sbyte(8'h00); sbyte(8'h00); close_win();
    check(!sdo_oe, "R10", "oe after close", sdo_oe, 0);

    // R6: wrap on write E,F,0 and on read F,0
    open_win(4'h3, 4'hE); sbyte(8'h11); sbyte(8'h22); sbyte(8'h33); close_win();
    check(regs[14] == 8'h11 && regs[15] == 8'h22 && regs[0] == 8'h33, "R6", "wrap write",
          regs[0], 8'h33);
    open_win(4'hC, 4'hF); sbyte(8'h00); sbyte(8'h00); close_win();

    // R3: unknown codes stay silent
    w0 = wv_cnt; o0 = oe_cnt;
    open_win(4'h5, 4'h1); sbyte(8'hFF); sbyte(8'h0F); close_win();
    open_win(4'hA, 4'h1); sbyte(8'hFF); close_win();
    check(wv_cnt == w0, "R3", "writes after bad code", wv_cnt - w0, 0);
    check(oe_cnt == o0, "R3", "oe after bad code", oe_cnt - o0, 0);

    // R1: only one enable high
    w0 = wv_cnt;
    ce_a = 1'b1; ce_b = 1'b0; tick(6);
    snib(4'h3); snib(4'h9); sbyte(8'h5A); sclk = 1'b0; tick(4);
    ce_a = 1'b0; ce_b = 1'b1; tick(6);
    snib(4'h3); snib(4'h9); sbyte(8'h5A); sclk = 1'b0; tick(4); ce_b = 1'b0; tick(8);
    check(wv_cnt == w0, "R1", "writes with one enable", wv_cnt - w0, 0);
    check(regs[9] == 8'(9 * 29 + 7), "R1", "regs[9]", regs[9], 8'(9 * 29 + 7));

    // R8: partial byte dropped, earlier byte kept
    a0 = ab_cnt;
    open_win(4'h3, 4'h4); sbyte(8'h77);
    for (int i = 0; i < 5; i++) sbit(1'b1);
    close_win();
    check(regs[4] == 8'h77, "R8", "regs[4] kept", regs[4], 8'h77);
    check(regs[5] == 8'(5 * 29 + 7), "R8", "regs[5] untouched", regs[5], 8'(5 * 29 + 7));
    check(ab_cnt == a0 + 1, "R8", "abort count", ab_cnt - a0, 1);

    // R8: closing in the same cycle as the eighth rise
    open_win(4'h3, 4'h6);
    for (int i = 0; i < 7; i++) sbit(1'b0);
    sdi = 1'b1; sclk = 1'b0; tick(4);
    sclk = 1'b1; ce_a = 1'b0; ce_b = 1'b0; tick(8); sclk = 1'b0; tick(4);
    check(regs[6] == 8'(6 * 29 + 7), "R8", "regs[6] on collision", regs[6], 8'(6 * 29 + 7));
    check(ab_cnt == a0 + 2, "R8", "collision abort", ab_cnt - a0, 2);

    // R10: close mid read byte
    open_win(4'hC, 4'h4);
    for (int i = 0; i < 3; i++) sbit(1'b0);
    sclk = 1'b0; ce_a = 1'b0; ce_b = 1'b0; tick(3);
    check(!sdo_oe && !sdo, "R10", "pad released", {sdo_oe, sdo}, 0);
    tick(6);

    // R2 R4: readback of the wrapped writes
    open_win(4'hC, 4'hE); sbyte(8'h00); sbyte(8'h00); sbyte(8'h00); close_win();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule